// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block is the device-side status logic for one flash bank while an internal program or erase runs. It accepts decoded commands, each one a single-cycle pulse that marks the final write strobe of a host command sequence. It holds the bank busy for a set number of clock cycles and, meanwhile, answers host reads with status words instead of array contents. The array programming itself is modelled by a busy counter and a small byte store. The store starts erased (all ones). A program can only clear bits. An erase sets a whole sector back to all ones.

While a program runs, a read at the program address returns bit 7 inverted relative to the byte being written. When the operation ends, the true data appears on the same cycle that the active-low ready/busy output returns high. A program or erase aimed at a protected sector keeps the bank busy only for a short window and then leaves the array untouched. An erase can be suspended. A program may then run in another sector, with the same bit-7 reporting, and the erase is later resumed from where it stopped.

Top module: `embed_status_poller`

## Requirements
- R1: After reset, ry_by_n is 1, no operation runs, and every byte reads 8'hFF.
- R2: A program command (cmd_op=3'd1) accepted while idle drives ry_by_n low from the next cycle for exactly BUSY_CYC cycles.
- R3: While a program runs, a read whose rd_addr equals the program address returns bit 7 equal to the inverse of bit 7 of the byte being programmed.
- R4: On the cycle a program ends, ry_by_n goes high and a read at the program address returns the old byte ANDed with the programmed byte.
- R5: While no status applies to the read address, rd_data returns the stored array byte.
- R6: A program or erase whose sector (address bits [ADDR_W-1:ADDR_W-SECT_W]) has its sect_prot bit set stays busy for PROT_CYC cycles only, with the same status words, and leaves the array unchanged.
- R7: A status word has bits 5:0 at zero. Bit 6 flips after every status read, and only after a status read.
- R8: An erase command (cmd_op=3'd2) accepted while idle holds ry_by_n low for ERASE_CYC cycles. Reads in the erasing sector return bit 7 at 0 during that time. Afterwards, all bytes of that sector read 8'hFF.
- R9: A suspend command (cmd_op=3'd3) during an erase sets ry_by_n high from the next cycle and freezes the remaining erase count. While suspended, reads in the erasing sector return 8'h80.
- R10: A program command while the erase is suspended behaves as in R2 to R4. Afterwards the bank returns to the suspended state. A program aimed at the suspended sector is ignored.
- R11: A resume command (cmd_op=3'd4) restarts the suspended erase. The erase then stays busy only for its remaining cycles.
- R12: Any command that does not fit the current state is ignored, and so is any cmd_op value other than 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command pulse: 0 none, 1 program, 2 erase, 3 suspend, 4 resume |
| cmd_addr | input | ADDR_W | Target address (program) or any address in the sector (erase) |
| cmd_data | input | 8 | Byte to program |
| sect_prot | input | 2**SECT_W | Per-sector protection, sampled when a command is accepted |
| rd_en | input | 1 | Host read strobe; advances the toggle bit on status reads |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Array byte or status word |
| ry_by_n | output | 1 | Low while a program or erase is running |

## Verification
Programs are run with bytes whose bit 7 is 0 and with bytes whose bit 7 is 1, so that an inverted status bit cannot be confused with a constant. Reads alternate between the target address, other bytes in the same sector and other sectors, which separates status reads from array reads. Protected and unprotected targets are compared to show the short window and the untouched array. An erase is suspended mid-way, a program runs in another sector, a program at the suspended sector is attempted, and the erase is resumed. This shows that the count freezes and that the bank returns to the suspended state. Misplaced and undefined command codes are issued in every state to confirm that they are ignored.

// File: rtl/embed_status_poller.sv
module embed_status_poller #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int BUSY_CYC  = 12,
  parameter int PROT_CYC  = 4,
  parameter int ERASE_CYC = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            cmd_op,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [7:0]            cmd_data,
  input  logic [(1<<SECT_W)-1:0] sect_prot,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic                  ry_by_n
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int SECT_SZ = 1 << (ADDR_W - SECT_W);
  localparam int MAXC    = (BUSY_CYC > ERASE_CYC) ? ((BUSY_CYC > PROT_CYC) ? BUSY_CYC : PROT_CYC)
                                                  : ((ERASE_CYC > PROT_CYC) ? ERASE_CYC : PROT_CYC);
  localparam int CW      = $clog2(MAXC + 1);

  localparam logic [2:0] OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_SUSP = 3'd3, OP_RESUME = 3'd4;
  localparam logic [2:0] S_IDLE = 3'd0, S_PROG = 3'd1, S_ERASE = 3'd2, S_SUSP = 3'd3, S_SPROG = 3'd4;

  logic [2:0]        st;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_data;
  logic              p_prot;
  logic [CW-1:0]     p_cnt;
  logic [SECT_W-1:0] e_sect;
  logic              e_prot;
  logic [CW-1:0]     e_cnt;
  logic              tog;
  logic [7:0]        mem [DEPTH];

  wire [SECT_W-1:0] cmd_sect = cmd_addr[ADDR_W-1 -: SECT_W];
  wire [SECT_W-1:0] rd_sect  = rd_addr[ADDR_W-1 -: SECT_W];
  wire prog_on  = (st == S_PROG) || (st == S_SPROG);
  wire prog_hit = prog_on && (rd_addr == p_addr);
  wire er_hit   = (st == S_ERASE) && (rd_sect == e_sect);
  wire sus_hit  = ((st == S_SUSP) || (st == S_SPROG)) && (rd_sect == e_sect);
  wire hit      = prog_hit || er_hit;

  assign ry_by_n = !(prog_on || st == S_ERASE);
  assign rd_data = prog_hit ? {~p_data[7], tog, 6'b0} :
                   er_hit   ? {1'b0, tog, 6'b0} :
                   sus_hit  ? 8'h80 : mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      p_addr <= '0; p_data <= '0; p_prot <= 1'b0; p_cnt <= '0;
      e_sect <= '0; e_prot <= 1'b0; e_cnt <= '0;
      tog <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (rd_en && hit) tog <= ~tog;
      case (st)
        S_IDLE: begin
          if (cmd_op == OP_PROG) begin
            p_addr <= cmd_addr; p_data <= cmd_data;
            p_prot <= sect_prot[cmd_sect];
            p_cnt  <= sect_prot[cmd_sect] ? CW'(PROT_CYC) : CW'(BUSY_CYC);
            st     <= S_PROG;
          end else if (cmd_op == OP_ERASE) begin
            e_sect <= cmd_sect;
            e_prot <= sect_prot[cmd_sect];
            e_cnt  <= sect_prot[cmd_sect] ? CW'(PROT_CYC) : CW'(ERASE_CYC);
            st     <= S_ERASE;
          end
        end
        S_PROG, S_SPROG: begin
          if (p_cnt == CW'(1)) begin
            if (!p_prot) mem[p_addr] <= mem[p_addr] & p_data;
            st <= (st == S_PROG) ? S_IDLE : S_SUSP;
          end else p_cnt <= p_cnt - CW'(1);
        end
        S_ERASE: begin
          if (cmd_op == OP_SUSP) st <= S_SUSP;
          else if (e_cnt == CW'(1)) begin
            if (!e_prot)
              for (int i = 0; i < DEPTH; i++)
                if (i / SECT_SZ == int'(e_sect)) mem[i] <= 8'hFF;
            st <= S_IDLE;
          end else e_cnt <= e_cnt - CW'(1);
        end
        S_SUSP: begin
          if (cmd_op == OP_RESUME) st <= S_ERASE;
          else if (cmd_op == OP_PROG && cmd_sect != e_sect) begin
            p_addr <= cmd_addr; p_data <= cmd_data;
            p_prot <= sect_prot[cmd_sect];
            p_cnt  <= sect_prot[cmd_sect] ? CW'(PROT_CYC) : CW'(BUSY_CYC);
            st     <= S_SPROG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/embed_status_poller_chk.sv
module embed_status_poller_chk #(parameter int CW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_op,
  input logic [2:0]    st,
  input logic [CW-1:0] e_cnt,
  input logic          ry_by_n,
  input logic          rd_en,
  input logic          hit,
  input logic          tog
);
  p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cmd_op == 3'd1) |=> !ry_by_n);
  p_erase_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cmd_op == 3'd2) |=> !ry_by_n);
  p_tog_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit) |=> (tog != $past(tog)));
  p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && hit) |=> $stable(tog));
  p_susp_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && cmd_op == 3'd3) |=> ry_by_n);
  p_susp_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> $stable(e_cnt));
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd3) |-> ry_by_n);
endmodule

bind embed_status_poller embed_status_poller_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .st(st), .e_cnt(e_cnt),
  .ry_by_n(ry_by_n), .rd_en(rd_en), .hit(hit), .tog(tog)
);

// File: tb/embed_status_poller_bench.sv
module embed_status_poller_bench;
  localparam int AW = 6, SW = 2, BC = 12, PC = 4, EC = 30;
  localparam int DEP = 1 << AW, SSZ = 1 << (AW - SW);

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0] cmd_data = 0;
  logic [(1<<SW)-1:0] sect_prot = 0;
  logic rd_en = 0;
  logic [7:0] rd_data;
  logic ry_by_n;

  always #2 clk = ~clk;

  embed_status_poller #(.ADDR_W(AW), .SECT_W(SW), .BUSY_CYC(BC), .PROT_CYC(PC), .ERASE_CYC(EC))
    u_embed_status_poller (.clk, .rst_n, .cmd_op, .cmd_addr, .cmd_data, .sect_prot,
                           .rd_en, .rd_addr, .rd_data, .ry_by_n);

  int vec = 0, bad = 0;
  string req = "R1";

  // reference model: 0 idle, 1 prog, 2 erase, 3 suspended, 4 prog in suspend
  int m_st, m_pa, m_pd, m_pp, m_pc, m_es, m_ep, m_ec, m_tog;
  int m_mem [DEP];

  function automatic int model_read(int a);
    bit pr = (m_st == 1 || m_st == 4);
    if (pr && a == m_pa) return ((((m_pd >> 7) & 1) ^ 1) << 7) | (m_tog << 6);
    if (m_st == 2 && a / SSZ == m_es) return m_tog << 6;
    if ((m_st == 3 || m_st == 4) && a / SSZ == m_es) return 8'h80;
    return m_mem[a];
  endfunction

  function automatic bit model_hit(int a);
    return ((m_st == 1 || m_st == 4) && a == m_pa) || (m_st == 2 && a / SSZ == m_es);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pa = 0; m_pd = 0; m_pp = 0; m_pc = 0;
      m_es = 0; m_ep = 0; m_ec = 0; m_tog = 0;
      for (int i = 0; i < DEP; i++) m_mem[i] = 255;
    end else begin
      int cs, op;
      cs = int'(cmd_addr) / SSZ;
      op = int'(cmd_op);
      if (rd_en && model_hit(int'(rd_addr))) m_tog ^= 1;
      case (m_st)
        0: if (op == 1) begin
             m_pa = cmd_addr; m_pd = cmd_data; m_pp = sect_prot[cs];
             m_pc = m_pp ? PC : BC; m_st = 1;
           end else if (op == 2) begin
             m_es = cs; m_ep = sect_prot[cs]; m_ec = m_ep ? PC : EC; m_st = 2;
           end
        1, 4: begin
             m_pc--;
             if (m_pc == 0) begin
               if (!m_pp) m_mem[m_pa] &= m_pd;
               m_st = (m_st == 1) ? 0 : 3;
             end
           end
        2: if (op == 3) m_st = 3;
           else begin
             m_ec--;
             if (m_ec == 0) begin
               if (!m_ep) for (int i = 0; i < SSZ; i++) m_mem[m_es*SSZ + i] = 255;
               m_st = 0;
             end
           end
        3: if (op == 4) m_st = 2;
           else if (op == 1 && cs != m_es) begin
             m_pa = cmd_addr; m_pd = cmd_data; m_pp = sect_prot[cs];
             m_pc = m_pp ? PC : BC; m_st = 4;
           end
        default: ;
      endcase
    end
  end

  task automatic compare();
    int er = model_read(int'(rd_addr));
    bit eb = !(m_st == 1 || m_st == 2 || m_st == 4);
    vec++;
    if (rd_data !== 8'(er)) begin
      bad++;
      $display("FAIL %s rd_data addr %0d got %h exp %h", req, rd_addr, rd_data, 8'(er));
    end
    vec++;
    if (ry_by_n !== eb) begin
      bad++;
      $display("FAIL %s ry_by_n got %b exp %b", req, ry_by_n, eb);
    end
  endtask

  task automatic step(input int op, input int ca, input int cd, input int ra, input bit re = 1);
    @(negedge clk);
    cmd_op = 3'(op); cmd_addr = AW'(ca); cmd_data = 8'(cd);
    rd_addr = AW'(ra); rd_en = re;
    #1 compare();
  endtask

  task automatic run_reads(input int n, input int a0, input int a1, input int a2);
    for (int k = 0; k < n; k++)
      step(0, 0, 0, (k % 3 == 0) ? a0 : (k % 3 == 1) ? a1 : a2, (k % 4) != 3);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; for (int a = 0; a < 8; a++) step(0, 0, 0, a * 7);
    req = "R2"; step(1, 5, 8'h3C, 5);
    req = "R3"; run_reads(BC + 3, 5, 6, 40);
    req = "R4"; run_reads(3, 5, 5, 5);
    req = "R2"; step(1, 9, 8'hA5, 9);
    req = "R7"; run_reads(BC + 2, 9, 9, 20);
    req = "R5"; run_reads(4, 9, 5, 63);
    req = "R12"; step(3, 0, 0, 5); step(4, 0, 0, 5); step(6, 5, 0, 5); step(7, 0, 0, 9);
    req = "R12"; step(1, 12, 8'h0F, 12); step(2, 12, 0, 12); step(1, 13, 0, 13);
    run_reads(BC + 2, 12, 13, 2);
    req = "R6"; sect_prot = 4'b0100;
    step(1, 37, 8'h00, 37); run_reads(PC + 4, 37, 36, 5);
    step(2, 40, 0, 40); run_reads(PC + 4, 41, 37, 5);
    sect_prot = 0;
    req = "R8"; step(1, 20, 8'h55, 20); run_reads(BC + 1, 20, 20, 20);
    step(2, 18, 0, 18); run_reads(EC + 4, 18, 20, 5);
    req = "R9"; step(1, 33, 8'h12, 33); run_reads(BC + 1, 33, 33, 33);
    step(2, 34, 0, 34); run_reads(10, 34, 35, 5);
    step(3, 0, 0, 34); run_reads(3, 34, 33, 5);
    req = "R10"; step(1, 35, 8'h00, 35); run_reads(3, 35, 33, 5);
    step(1, 50, 8'h71, 50); run_reads(BC + 2, 50, 34, 51);
    step(2, 0, 0, 50); step(3, 0, 0, 50);
    req = "R11"; step(4, 0, 0, 34); run_reads(EC, 34, 33, 50);
    req = "R5"; run_reads(6, 33, 50, 35);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule